// File: doc/BRIEF.md
# Prioritised Programmable Chip-Select Decoder

This block turns the page bits of a 20-bit physical address into exactly one of six device selects: four memory banks, one IO page and an external window. Each select has an 8-bit configuration register, loaded through a small write port. A memory or external register gives a 64 KB-granular window. Its upper nibble is the base for address bits 19:16. Its lower nibble is a care mask: a set bit means that address bit is compared, and a cleared bit widens the window. The IO register names a single 4 KB page by address bits 19:12.

Windows may overlap. A fixed priority settles which select wins, and an address that no window claims goes to the external select. Before address translation is switched on, the CPU's top logical 4 KB page is routed to memory bank 3, so boot code can run from there while every register still holds its cleared value.

Top module: `csd_chip_select`

## Requirements
- R1: A synchronous reset clears all six configuration registers; with those values and no boot override, every address selects EXT.
- R2: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_off` (2 = IO, 3 = EXT, 4..7 = MEM0..MEM3), and the decode uses the new value from the next cycle on.
- R3: Writes at offsets 0 and 1, and cycles with `wr_en` low, change no register.
- R4: MEM0..MEM3 and EXT each match when ((A19:16 xor reg[7:4]) and reg[3:0]) is zero.
- R5: IO matches when A19:12 equals all 8 bits of the IO register.
- R6: When several windows match, the winner is, from highest to lowest: EXT, IO, MEM3, MEM2, MEM1, MEM0.
- R7: An address that no window matches selects EXT.
- R8: With `xlat_en` low and `log_page` equal to 4'hF, MEM3 is selected, whatever the physical address and the registers hold.
- R9: `sel` has exactly one bit set at all times: bit 0 MEM0, bit 1 MEM1, bit 2 MEM2, bit 3 MEM3, bit 4 IO, bit 5 EXT.
- R10: With `xlat_en` low and `log_page` other than 4'hF, the physical address is decoded as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 3 | Register offset within the 8-byte system register block |
| wr_data | input | 8 | Write data |
| phys_page | input | 8 | Physical address bits 19:12 |
| xlat_en | input | 1 | Address translation is enabled |
| log_page | input | 4 | Logical CPU address bits 15:12 |
| sel | output | 6 | One-hot device select |

## Verification
The hardest situation to reach is one where lower-priority windows are visible at all: after reset the external window covers the whole space, so MEM, IO and the fallback path only show once the external care mask is set and other windows overlap beneath it. The bench programs a nested layout by hand (a 1 MB bank, a 256 KB bank, a 64 KB bank, an IO page and a narrow bank 3 over them, a 64 KB external window on top), then a layout with holes for the fallback. Random rounds reprogram all registers, biased towards non-zero external masks, and mix in writes at the reserved offsets.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int PAGE_W  = 8;   // physical address bits 19:12
    localparam int NIB_W   = 4;   // bits 19:16 compared by windows
    localparam int N_MEM   = 4;
    localparam int N_SEL   = N_MEM + 2;
    localparam int OFF_W   = 3;
    localparam int LPAGE_W = 4;

    localparam logic [OFF_W-1:0] OFF_IO   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_EXT  = 3'd3;
    localparam int               OFF_MEM0 = 4;

    typedef enum logic [2:0] {
        SEL_MEM0 = 3'd0,
        SEL_MEM1 = 3'd1,
        SEL_MEM2 = 3'd2,
        SEL_MEM3 = 3'd3,
        SEL_IO   = 3'd4,
        SEL_EXT  = 3'd5
    } sel_e;

    typedef struct packed {
        logic [NIB_W-1:0] base;
        logic [NIB_W-1:0] care;
    } win_cfg_t;

    typedef struct packed {
        win_cfg_t [N_MEM-1:0] mem;
        win_cfg_t             ext;
        logic [PAGE_W-1:0]    io;
    } map_cfg_t;

    function automatic logic win_hit(input win_cfg_t c, input logic [NIB_W-1:0] nib);
        return ((nib ^ c.base) & c.care) == '0;
    endfunction

    function automatic logic [N_SEL-1:0] sel_to_onehot(input sel_e s);
        logic [N_SEL-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
    import csd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    output map_cfg_t         cfg
);

    logic [PAGE_W-1:0] io_q;
    win_cfg_t          ext_q;
    win_cfg_t          mem_q [N_MEM];

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q  <= '0;
            ext_q <= '0;
        end else if (wr_en) begin
            if (wr_off == OFF_IO)  io_q  <= wr_data;
            if (wr_off == OFF_EXT) ext_q <= win_cfg_t'(wr_data);
        end
    end

    for (genvar g = 0; g < N_MEM; g++) begin : g_mem
        always_ff @(posedge clk) begin
            if (rst)
                mem_q[g] <= '0;
            else if (wr_en && wr_off == OFF_W'(OFF_MEM0 + g))
                mem_q[g] <= win_cfg_t'(wr_data);
        end
        assign cfg.mem[g] = mem_q[g];
    end

    assign cfg.io  = io_q;
    assign cfg.ext = ext_q;

    // R3: reserved offsets leave every register untouched
    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off < OFF_IO) |=> $stable(cfg));

    // R3: idle cycles leave every register untouched
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

    // R2: a write at the external offset lands in the external register
    a_r2_ext_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_off == OFF_EXT) |=> (cfg.ext == win_cfg_t'($past(wr_data))));

endmodule

// File: rtl/csd_hit_vec.sv
module csd_hit_vec
    import csd_pkg::*;
(
    input  map_cfg_t          cfg,
    input  logic [PAGE_W-1:0] phys_page,
    output logic [N_SEL-1:0]  hit
);

    logic [NIB_W-1:0] nib;
    assign nib = phys_page[PAGE_W-1 -: NIB_W];

    for (genvar g = 0; g < N_MEM; g++) begin : g_win
        assign hit[g] = win_hit(cfg.mem[g], nib);
    end

    assign hit[SEL_IO]  = (phys_page == cfg.io);
    assign hit[SEL_EXT] = win_hit(cfg.ext, nib);

endmodule

// File: rtl/csd_prio_pick.sv
module csd_prio_pick
    import csd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SEL-1:0] hit,
    input  logic             boot,
    output logic [N_SEL-1:0] sel
);

    sel_e win;

    always_comb begin
        logic found;
        found = 1'b0;
        win   = SEL_EXT;
        for (int i = N_SEL - 1; i >= 0; i--) begin
            if (!found && hit[i]) begin
                win   = sel_e'(3'(i));
                found = 1'b1;
            end
        end
        if (boot) win = SEL_MEM3;
    end

    assign sel = sel_to_onehot(win);

    // R9: exactly one select at a time
    a_r9_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot(sel));

    // R6: the external window beats every other window
    a_r6_ext_wins: assert property (@(posedge clk) disable iff (rst)
        (!boot && hit[SEL_EXT]) |-> sel[SEL_EXT]);

    // R6: IO beats every memory bank
    a_r6_io_over_mem: assert property (@(posedge clk) disable iff (rst)
        (!boot && hit[SEL_IO] && !hit[SEL_EXT]) |-> sel[SEL_IO]);

    // R7: nothing claimed falls to the external select
    a_r7_fallback: assert property (@(posedge clk) disable iff (rst)
        (!boot && hit == '0) |-> sel[SEL_EXT]);

endmodule

// File: rtl/csd_chip_select.sv
module csd_chip_select
    import csd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [7:0]         wr_data,
    input  logic [PAGE_W-1:0]  phys_page,
    input  logic               xlat_en,
    input  logic [LPAGE_W-1:0] log_page,
    output logic [N_SEL-1:0]   sel
);

    map_cfg_t         cfg;
    logic [N_SEL-1:0] hit;
    logic             boot;

    assign boot = !xlat_en && (log_page == '1);

    csd_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    csd_hit_vec u_hit (
        .cfg       (cfg),
        .phys_page (phys_page),
        .hit       (hit)
    );

    csd_prio_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit),
        .boot (boot),
        .sel  (sel)
    );

    // R8: the boot page always reaches bank 3 before translation is on
    a_r8_boot_mem3: assert property (@(posedge clk) disable iff (rst)
        (!xlat_en && log_page == 4'hF) |-> (sel == 6'b001000));

    // R1: one cycle after reset the external select owns the whole space
    a_r1_after_reset: assert property (@(posedge clk)
        (rst && xlat_en) |=> (xlat_en && !wr_en && $stable(phys_page)) |-> sel[SEL_EXT]);

endmodule

// File: tb/tb_csd_chip_select.sv
module tb_csd_chip_select;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_off;
    logic [7:0] wr_data;
    logic [7:0] phys_page;
    logic       xlat_en;
    logic [3:0] log_page;
    logic [5:0] sel;

    int checks = 0;
    int bad    = 0;

    logic [7:0] sh [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    csd_chip_select dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .phys_page (phys_page),
        .xlat_en   (xlat_en),
        .log_page  (log_page),
        .sel       (sel)
    );

    function automatic logic [5:0] ref_sel(input logic [7:0] pp, input logic xl,
                                           input logic [3:0] lp);
        if (!xl && lp == 4'hF) return 6'b001000;                       // R8
        if (((pp[7:4] ^ sh[3][7:4]) & sh[3][3:0]) == 4'h0) return 6'b100000;
        if (pp == sh[2]) return 6'b010000;                             // R5
        for (int m = 3; m >= 0; m--)
            if (((pp[7:4] ^ sh[4+m][7:4]) & sh[4+m][3:0]) == 4'h0)
                return 6'(1 << m);                                     // R4 R6
        return 6'b100000;                                              // R7
    endfunction

    task automatic wr(input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (off >= 3'd2) sh[off] = d;   // R2 / R3 model
    endtask

    task automatic chk(input logic [7:0] pp, input logic xl, input logic [3:0] lp,
                       input string tag);
        logic [5:0] exp;
        phys_page = pp; xlat_en = xl; log_page = lp;
        #1;
        exp = ref_sel(pp, xl, lp);
        checks++;
        if (sel !== exp || $countones(sel) != 1) begin
            bad++;
            $display("FAIL %s R9: page=%h xl=%b lp=%h got=%b expected=%b",
                     tag, pp, xl, lp, sel, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20231));
        for (int i = 0; i < 8; i++) sh[i] = 8'h00;
        rst = 1'b1; wr_en = 1'b0; wr_off = '0; wr_data = '0;
        phys_page = '0; xlat_en = 1'b1; log_page = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, everything external
        chk(8'h12, 1'b1, 4'h0, "R1 reset");
        chk(8'hF0, 1'b1, 4'h3, "R1 reset");
        chk(8'h00, 1'b0, 4'h1, "R1 R10 reset no xlat");
        // R8: boot page with cleared registers
        chk(8'h47, 1'b0, 4'hF, "R8 boot");

        // R2 R4 R5 R6: nested layout
        wr(3'd4, 8'h00);   // MEM0 whole space
        wr(3'd5, 8'h0C);   // MEM1 256 KB at 0
        wr(3'd6, 8'h0F);   // MEM2 64 KB at 0
        wr(3'd7, 8'h8C);   // MEM3 256 KB at 0x80000
        wr(3'd2, 8'h80);   // IO page 0x80
        wr(3'd3, 8'hFF);   // EXT 64 KB at 0xF0000
        chk(8'h05, 1'b1, 4'h0, "R6 mem2 over mem1");
        chk(8'h25, 1'b1, 4'h0, "R6 mem1 over mem0");
        chk(8'h55, 1'b1, 4'h0, "R4 mem0 wide");
        chk(8'h80, 1'b1, 4'h0, "R5 R6 io over mem3");
        chk(8'h81, 1'b1, 4'h0, "R4 mem3 beside io");
        chk(8'hF1, 1'b1, 4'h0, "R6 ext top");
        chk(8'hF1, 1'b0, 4'hF, "R8 boot over ext");
        chk(8'h25, 1'b0, 4'h7, "R10 no xlat decode");

        // R3: reserved offsets and idle cycles
        wr(3'd0, 8'h0F);
        wr(3'd1, 8'h00);
        @(negedge clk); wr_off = 3'd3; wr_data = 8'h00;
        @(negedge clk);
        chk(8'h25, 1'b1, 4'h0, "R3 reserved ignored");
        chk(8'h80, 1'b1, 4'h0, "R3 reserved ignored");

        // R7: layout with holes
        wr(3'd4, 8'h1F); wr(3'd5, 8'h2F); wr(3'd6, 8'h3F); wr(3'd7, 8'h4F);
        wr(3'd2, 8'h50); wr(3'd3, 8'hFF);
        chk(8'h70, 1'b1, 4'h0, "R7 unclaimed");
        chk(8'h00, 1'b1, 4'h0, "R7 unclaimed");
        chk(8'h1A, 1'b1, 4'h0, "R4 mem0 64k");
        chk(8'h50, 1'b1, 4'h0, "R5 io page");
        chk(8'h51, 1'b1, 4'h0, "R5 R7 io neighbour");

        // random rounds
        for (int r = 0; r < 60; r++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] d;
                d = 8'($urandom);
                if (k == 3 && ($urandom % 4) != 0) d[3:0] = d[3:0] | 4'b1100;
                wr(3'(k), d);
            end
            for (int a = 0; a < 24; a++)
                chk(8'($urandom), ($urandom % 5) != 0, 4'($urandom), "R4 R5 R6 R7 random");
        end

        // R1: reset again clears a programmed map
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) sh[i] = 8'h00;
        chk(8'h1A, 1'b1, 4'h0, "R1 re-reset");

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule